// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This controller connects a simple synchronous request bus to an external asynchronous static RAM of 512K bytes. The RAM has a 19-bit address, active-low select, write strobe and read strobe, and one 8-bit bidirectional data bus. Here that bus is split into a byte driven out, a byte read in and an enable for the controller's own driver. A requester raises a one-cycle request with a write flag, an address and a write byte. The controller then runs one complete RAM access and returns to standby, with every strobe high, between accesses.

Every pin phase is a whole number of system clock cycles. Each count comes from the RAM's nanosecond limits by rounding up against a clock-period parameter. One parameter selects the faster or the slower timing set. Writes are ended by the write strobe. The controller keeps its data driver off until the RAM's output can no longer be driving.

Top module: `async_sram_ctrl`

## Requirements
- R1: After reset, and until a request is accepted, `sram_cs_n`, `sram_we_n` and `sram_oe_n` are 1, `sram_doe` is 0, and `busy` and `rd_valid` are 0.
- R2: The controller never drives `sram_we_n` and `sram_oe_n` low together. A read drives `sram_cs_n`=0, `sram_oe_n`=0 and `sram_we_n`=1. A write keeps `sram_oe_n`=1.
- R3: A read holds `sram_cs_n` and `sram_oe_n` low for ACC cycles, where ACC = ceil(max(address access, read-enable access) / CLK_NS). ACC is 6 for the fast set at 10 ns and 7 for the slow set. The byte on `sram_din` is captured at the last of those edges, and both strobes rise at that same edge. `rd_valid` is then 1 for exactly one cycle, carrying that byte on `rd_data`.
- R4: A write spends one cycle with address and data driven and all strobes high. It then holds `sram_cs_n` and `sram_we_n` low for WP cycles, where WP = ceil of the largest of write pulse, select-to-end, address-to-end and data setup. WP is 5 fast and 6 slow. Both strobes rise together while data is still driven, and the driver is released one cycle later. Address and data stay constant throughout.
- R5: `sram_doe` is 0 whenever the RAM may drive the bus. That covers every cycle with the RAM read-enabled, and the ceil(20 ns / CLK_NS) cycles after the read strobe rises.
- R6: `busy` rises in the cycle after acceptance. For a read it stays high for max(ceil(read cycle), ACC + ceil(20 ns)) cycles: 8 fast, 9 slow. For a write it stays high for max(ceil(write cycle), WP + 2) cycles: 7 fast, 8 slow.
- R7: A request presented while `busy` is 1 is ignored. It causes no strobe activity, no `rd_valid` and no change to memory contents.
- R8: Parameter SLOW=0 selects 55 ns cycles, a 45 ns write pulse, 50 ns select/address-to-end, 25 ns data setup and 30 ns read-enable access. SLOW=1 selects 70 ns, 50 ns, 60 ns, 30 ns and 35 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, accepted when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write byte |
| busy | output | 1 | Access in progress |
| rd_valid | output | 1 | One-cycle read completion pulse |
| rd_data | output | DW | Captured read byte |
| sram_addr | output | AW | RAM address |
| sram_cs_n | output | 1 | RAM select, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_oe_n | output | 1 | RAM read strobe, active low |
| sram_dout | output | DW | Byte driven toward the RAM |
| sram_doe | output | 1 | Enable of the controller's data driver |
| sram_din | input | DW | Byte read from the RAM bus |

## Verification
The assertions take for granted that `req` is a synchronous pulse whose write flag, address and byte are stable at the sampling edge. They also assume the requester does not rely on a request made while busy. The stimulus changes inputs only on falling edges and holds a request for one cycle. It drives stray requests only while `busy` is high, at a known cycle, so their rejection can be checked.

The bench's RAM model returns a poison byte until the select has been low for the address access time. It also counts any overlap between the controller's driver and the RAM's output window.

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl #(
  parameter int CLK_NS = 10,
  parameter bit SLOW   = 1'b0,
  parameter int AW     = 19,
  parameter int DW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] sram_addr,
  output logic          sram_cs_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [DW-1:0] sram_dout,
  output logic          sram_doe,
  input  logic [DW-1:0] sram_din
);

  function automatic int cyc(input int ns);
    return (ns <= 0) ? 0 : (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int T_RC = SLOW ? 70 : 55;
  localparam int T_AA = SLOW ? 70 : 55;
  localparam int T_OE = SLOW ? 35 : 30;
  localparam int T_HZ = 20;
  localparam int T_WC = SLOW ? 70 : 55;
  localparam int T_WP = SLOW ? 50 : 45;
  localparam int T_CW = SLOW ? 60 : 50;
  localparam int T_AW = SLOW ? 60 : 50;
  localparam int T_DW = SLOW ? 30 : 25;

  localparam int ACC    = imax(cyc(imax(T_AA, T_OE)), 1);
  localparam int HZ     = imax(cyc(T_HZ), 1);
  localparam int RD_REC = imax(cyc(T_RC) - ACC, HZ);
  localparam int WP     = imax(imax(imax(cyc(T_WP), cyc(T_CW)), imax(cyc(T_AW), cyc(T_DW))), 1);
  localparam int WR_REC = imax(cyc(T_WC) - WP - 2, 0);
  localparam int CW     = $clog2(imax(imax(ACC, RD_REC), imax(WP, WR_REC + 1)) + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RACC, S_RREC, S_WSET, S_WPUL, S_WHLD, S_WREC
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          cnt_done;

  assign busy     = (st != S_IDLE);
  assign cnt_done = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      sram_cs_n <= 1'b1;
      sram_we_n <= 1'b1;
      sram_oe_n <= 1'b1;
      sram_doe  <= 1'b0;
      sram_addr <= '0;
      sram_dout <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          sram_addr <= req_addr;
          if (req_wr) begin
            sram_dout <= req_wdata;
            sram_doe  <= 1'b1;
            st        <= S_WSET;
          end else begin
            sram_cs_n <= 1'b0;
            sram_oe_n <= 1'b0;
            cnt       <= CW'(ACC - 1);
            st        <= S_RACC;
          end
        end
        S_RACC: if (cnt_done) begin
          rd_data   <= sram_din;
          rd_valid  <= 1'b1;
          sram_cs_n <= 1'b1;
          sram_oe_n <= 1'b1;
          cnt       <= CW'(RD_REC - 1);
          st        <= S_RREC;
        end else cnt <= cnt - 1'b1;
        S_RREC: if (cnt_done) st <= S_IDLE;
                else cnt <= cnt - 1'b1;
        S_WSET: begin
          sram_cs_n <= 1'b0;
          sram_we_n <= 1'b0;
          cnt       <= CW'(WP - 1);
          st        <= S_WPUL;
        end
        S_WPUL: if (cnt_done) begin
          sram_cs_n <= 1'b1;
          sram_we_n <= 1'b1;
          st        <= S_WHLD;
        end else cnt <= cnt - 1'b1;
        S_WHLD: begin
          sram_doe <= 1'b0;
          if (WR_REC == 0) st <= S_IDLE;
          else begin
            cnt <= CW'(imax(WR_REC - 1, 0));
            st  <= S_WREC;
          end
        end
        S_WREC: if (cnt_done) st <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_we_oe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n);

  p_we_needs_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_cs_n && sram_doe));

  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

  p_data_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_doe && $past(sram_doe)) |-> $stable(sram_dout));

  p_no_drive_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sram_doe |-> sram_oe_n);

  p_hz_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_oe_n) |=> !sram_doe);

  p_rdv_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_rdv_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (busy && sram_cs_n && sram_oe_n));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sram_cs_n && sram_we_n && sram_oe_n && !sram_doe));

endmodule

// File: tb/test_async_sram_ctrl.sv
module sram_model #(
  parameter int CLK_NS = 10,
  parameter int T_AA   = 55,
  parameter int T_HZ   = 20
) (
  input  logic        clk,
  input  logic        cs_n,
  input  logic        we_n,
  input  logic        oe_n,
  input  logic [18:0] addr,
  input  logic [7:0]  dout,
  input  logic        doe,
  output logic [7:0]  din,
  output int          conflicts,
  output int          bad_writes,
  output int          decode_errs
);
  logic [7:0] mem [int unsigned];
  int hz = 0;
  int low = 0;
  logic prev_we = 1'b1;
  logic drive;

  initial begin
    din = 8'hEE; conflicts = 0; bad_writes = 0; decode_errs = 0;
  end

  always @(negedge clk) begin
    drive = !cs_n && !oe_n && we_n;
    if (doe && (drive || hz > 0)) conflicts++;
    if (!we_n && !oe_n) decode_errs++;
    if (drive) begin
      hz = (T_HZ + CLK_NS - 1) / CLK_NS;
      low++;
    end else begin
      if (hz > 0) hz--;
      low = 0;
    end
    if (prev_we === 1'b0 && we_n === 1'b1) begin
      if (!doe) bad_writes++;
      mem[int'(addr)] = dout;
    end
    prev_we = we_n;
    if (drive && low * CLK_NS >= T_AA)
      din = mem.exists(int'(addr)) ? mem[int'(addr)] : (addr[7:0] ^ 8'h5A);
    else
      din = 8'hEE;
  end
endmodule

module test_async_sram_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req     [2];
  logic        req_wr  [2];
  logic [18:0] req_addr[2];
  logic [7:0]  req_wd  [2];
  logic        busy    [2];
  logic        rdv     [2];
  logic [7:0]  rdd     [2];
  logic [18:0] s_addr  [2];
  logic        s_cs    [2];
  logic        s_we    [2];
  logic        s_oe    [2];
  logic [7:0]  s_dout  [2];
  logic        s_doe   [2];
  logic [7:0]  s_din   [2];
  int          confl   [2];
  int          badw    [2];
  int          decerr  [2];

  async_sram_ctrl #(.CLK_NS(CLK_PERIOD), .SLOW(1'b0)) i_async_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req[0]), .req_wr(req_wr[0]),
    .req_addr(req_addr[0]), .req_wdata(req_wd[0]), .busy(busy[0]),
    .rd_valid(rdv[0]), .rd_data(rdd[0]), .sram_addr(s_addr[0]),
    .sram_cs_n(s_cs[0]), .sram_we_n(s_we[0]), .sram_oe_n(s_oe[0]),
    .sram_dout(s_dout[0]), .sram_doe(s_doe[0]), .sram_din(s_din[0]));

  async_sram_ctrl #(.CLK_NS(CLK_PERIOD), .SLOW(1'b1)) i_async_sram_ctrl_slow (
    .clk(clk), .rst_n(rst_n), .req(req[1]), .req_wr(req_wr[1]),
    .req_addr(req_addr[1]), .req_wdata(req_wd[1]), .busy(busy[1]),
    .rd_valid(rdv[1]), .rd_data(rdd[1]), .sram_addr(s_addr[1]),
    .sram_cs_n(s_cs[1]), .sram_we_n(s_we[1]), .sram_oe_n(s_oe[1]),
    .sram_dout(s_dout[1]), .sram_doe(s_doe[1]), .sram_din(s_din[1]));

  sram_model #(.CLK_NS(CLK_PERIOD), .T_AA(55)) m_fast (
    .clk(clk), .cs_n(s_cs[0]), .we_n(s_we[0]), .oe_n(s_oe[0]), .addr(s_addr[0]),
    .dout(s_dout[0]), .doe(s_doe[0]), .din(s_din[0]),
    .conflicts(confl[0]), .bad_writes(badw[0]), .decode_errs(decerr[0]));

  sram_model #(.CLK_NS(CLK_PERIOD), .T_AA(70)) m_slow (
    .clk(clk), .cs_n(s_cs[1]), .we_n(s_we[1]), .oe_n(s_oe[1]), .addr(s_addr[1]),
    .dout(s_dout[1]), .doe(s_doe[1]), .din(s_din[1]),
    .conflicts(confl[1]), .bad_writes(badw[1]), .decode_errs(decerr[1]));

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] shadow [int unsigned];

  function automatic int ceil_c(input int ns);
    return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
  endfunction
  function automatic int mx(input int a, input int b);
    return a > b ? a : b;
  endfunction
  function automatic int exp_acc(input int g);
    return ceil_c(g ? 70 : 55);
  endfunction
  function automatic int exp_wp(input int g);
    return ceil_c(g ? mx(mx(50, 60), 30) : mx(mx(45, 50), 25));
  endfunction
  function automatic int exp_rbusy(input int g);
    return mx(ceil_c(g ? 70 : 55), exp_acc(g) + ceil_c(20));
  endfunction
  function automatic int exp_wbusy(input int g);
    return mx(ceil_c(g ? 70 : 55), exp_wp(g) + 2);
  endfunction
  function automatic logic [7:0] init_byte(input logic [18:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic op(input int g, input bit wr, input logic [18:0] a,
                    input logic [7:0] d, input bit stray, output logic [7:0] got);
    int k = 0;
    int perr = 0;
    int rv = 0;
    bit ecs, ewe, eoe, edoe, erv;
    got = 8'h00;
    @(negedge clk);
    req[g] = 1'b1; req_wr[g] = wr; req_addr[g] = a; req_wd[g] = d;
    @(negedge clk);
    req[g] = 1'b0;
    while (busy[g] && k < 100) begin
      k++;
      if (wr) begin
        ecs = !(k >= 2 && k <= exp_wp(g) + 1); ewe = ecs; eoe = 1'b1;
        edoe = (k <= exp_wp(g) + 2); erv = 1'b0;
      end else begin
        ecs = !(k <= exp_acc(g)); eoe = ecs; ewe = 1'b1;
        edoe = 1'b0; erv = (k == exp_acc(g) + 1);
      end
      if (s_cs[g] !== ecs || s_we[g] !== ewe || s_oe[g] !== eoe ||
          s_doe[g] !== edoe || rdv[g] !== erv) perr++;
      if (!s_cs[g] && s_addr[g] !== a) perr++;
      if (wr && s_doe[g] && s_dout[g] !== d) perr++;
      if (rdv[g]) begin rv++; got = rdd[g]; end
      if (stray && k == 2) begin
        req[g] = 1'b1; req_wr[g] = !wr; req_addr[g] = a ^ 19'h1; req_wd[g] = ~d;
      end else req[g] = 1'b0;
      @(negedge clk);
    end
    req[g] = 1'b0;
    if (s_cs[g] !== 1'b1 || s_we[g] !== 1'b1 || s_oe[g] !== 1'b1 || s_doe[g] !== 1'b0) perr++;
    if (wr) chk(perr == 0, "R4 write pin sequence", perr, 0);
    else    chk(perr == 0, "R3 read pin sequence", perr, 0);
    chk(k == (wr ? exp_wbusy(g) : exp_rbusy(g)), "R6 busy length", k,
        wr ? exp_wbusy(g) : exp_rbusy(g));
    if (!wr) chk(rv == 1, "R3 single rd_valid", rv, 1);
    if (stray) begin
      chk(perr == 0, "R7 stray request left pins unchanged", perr, 0);
      if (wr) chk(rv == 0, "R7 stray read gave no rd_valid", rv, 0);
    end
  endtask

  task automatic check_idle(input int g, input string tag);
    chk(s_cs[g] === 1'b1 && s_we[g] === 1'b1 && s_oe[g] === 1'b1 && s_doe[g] === 1'b0 &&
        busy[g] === 1'b0 && rdv[g] === 1'b0, tag,
        {s_cs[g], s_we[g], s_oe[g], s_doe[g], busy[g], rdv[g]}, 6'b111000);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] got;
    logic [18:0] a;
    logic [7:0] d;
    bit wr, st;
    void'($urandom(32'h5eed_1234));
    for (int g = 0; g < 2; g++) begin
      req[g] = 1'b0; req_wr[g] = 1'b0; req_addr[g] = '0; req_wd[g] = '0;
    end
    repeat (3) @(negedge clk);
    check_idle(0, "R1 reset state fast");
    check_idle(1, "R1 reset state slow");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle(0, "R1 idle after reset");

    op(0, 1'b0, 19'h7FFFF, 8'h00, 1'b0, got);
    chk(got == init_byte(19'h7FFFF), "R3 read top address", got, init_byte(19'h7FFFF));
    op(0, 1'b1, 19'h00000, 8'hA5, 1'b0, got);
    op(0, 1'b0, 19'h00000, 8'h00, 1'b0, got);
    chk(got == 8'hA5, "R3 read back address zero", got, 8'hA5);
    op(0, 1'b1, 19'h7FFFF, 8'h3C, 1'b0, got);
    op(0, 1'b0, 19'h7FFFF, 8'h00, 1'b0, got);
    chk(got == 8'h3C, "R3 read back top address", got, 8'h3C);

    op(0, 1'b1, 19'h00100, 8'h11, 1'b0, got);
    op(0, 1'b0, 19'h00100, 8'h00, 1'b1, got);
    chk(got == 8'h11, "R7 read during stray write", got, 8'h11);
    op(0, 1'b0, 19'h00101, 8'h00, 1'b0, got);
    chk(got == init_byte(19'h00101), "R7 stray write not stored", got, init_byte(19'h00101));
    op(0, 1'b1, 19'h00102, 8'h77, 1'b1, got);

    op(1, 1'b1, 19'h12345, 8'h9E, 1'b0, got);
    op(1, 1'b0, 19'h12345, 8'h00, 1'b0, got);
    chk(got == 8'h9E, "R8 slow grade read back", got, 8'h9E);
    op(1, 1'b0, 19'h00200, 8'h00, 1'b1, got);
    chk(got == init_byte(19'h00200), "R8 slow grade unwritten", got, init_byte(19'h00200));
    op(1, 1'b0, 19'h00201, 8'h00, 1'b0, got);
    chk(got == init_byte(19'h00201), "R7 slow stray write not stored", got, init_byte(19'h00201));

    for (int i = 0; i < 250; i++) begin
      wr = $urandom() % 2 == 0;
      a  = 19'h00200 + 19'(($urandom() % 16) * 16);
      d  = 8'($urandom());
      st = $urandom() % 4 == 0;
      op(0, wr, a, d, st, got);
      if (wr) shadow[int'(a)] = d;
      else chk(got == (shadow.exists(int'(a)) ? shadow[int'(a)] : init_byte(a)),
               "R3 random read data", got,
               shadow.exists(int'(a)) ? shadow[int'(a)] : init_byte(a));
    end

    for (int g = 0; g < 2; g++) begin
      chk(confl[g] == 0, "R5 no driver overlap with RAM output", confl[g], 0);
      chk(decerr[g] == 0, "R2 write and read strobes never both low", decerr[g], 0);
      chk(badw[g] == 0, "R4 data driven at end of write", badw[g], 0);
    end
    summary();
  end
endmodule